// File: doc/BRIEF.md
# Row-Hit-First Request Scheduler

This block sits in front of one DRAM bank (or one channel treated as a single bank). It keeps up to eight pending memory requests, each holding a row, a column and a read/write flag. Every cycle it names one request as the candidate to serve next and tells the command sequencer which kind of DRAM command that request needs now. The sequencer takes the candidate by raising the select enable, and the entry then leaves the queue at the clock edge.

Two ranking modes are offered. In the row-hit-first mode, any request whose row matches the row currently held open in the bank is preferred, because it needs only a column command. The order of arrival breaks ties within a class. In strict arrival mode the earliest request still waiting is always chosen, whatever its row. Arrival order is kept as a pairwise "older-than" matrix, so it never depends on a wrapping stamp. Ranking and the command class follow the open-row inputs combinationally, which means a change of the open row is reflected in the same cycle.

Top module: `frfcfs_sched`

## Requirements
- R1: After reset the queue is empty: `pick_valid` and `deq` are 0 and `enq_ready` is 1.
- R2: The queue holds at most 8 requests. `enq_ready` is 0 while 8 are held. An enqueue offered while full is dropped and never appears later, even when a dequeue happens in that same cycle.
- R3: With `fcfs_mode` = 1 the candidate is always the earliest-arrived request still queued, whether or not its row is open.
- R4: With `fcfs_mode` = 0, if any queued request targets the open row (`open_valid` = 1 and row equal to `open_row`), the candidate is one of those requests.
- R5: Among requests of the same hit status, the earliest arrival is chosen.
- R6: `pick_cmd` gives the command class of the candidate. It is 0 for a column read on a row hit with the write flag 0, and 1 for a column write on a row hit with the write flag 1. It is 2 (activate) when no row is open, and 3 (precharge) when a different row is open.
- R7: A change of `open_row`, `open_valid` or `fcfs_mode` changes the candidate and its command class in the same cycle, with no clock edge needed.
- R8: `deq` equals `sel_en` AND `pick_valid`. The candidate is removed from the queue at that clock edge.
- R9: An enqueue and a dequeue in the same cycle both take effect. The new request ranks as younger than every request already queued, including after slots have been reused.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Offer a new request |
| enq_row | input | ROW_W (14) | Row of the offered request |
| enq_col | input | COL_W (11) | Column of the offered request |
| enq_wr | input | 1 | 1 = write, 0 = read |
| enq_ready | output | 1 | Queue has a free slot |
| open_valid | input | 1 | The bank currently holds a row open |
| open_row | input | ROW_W (14) | Row held open in the bank |
| fcfs_mode | input | 1 | 1 = strict arrival order, 0 = row-hit first |
| sel_en | input | 1 | Sequencer takes the candidate this cycle |
| pick_valid | output | 1 | A candidate exists |
| pick_idx | output | 3 | Queue slot of the candidate |
| pick_row | output | ROW_W (14) | Row of the candidate |
| pick_col | output | COL_W (11) | Column of the candidate |
| pick_wr | output | 1 | Write flag of the candidate |
| pick_cmd | output | 2 | Command class (R6 encoding) |
| deq | output | 1 | Candidate leaves the queue at this edge |

## Verification
A corrupted age matrix shows up at the ports as a later arrival being served before an earlier one. This is visible on `pick_col` in the first cycle that the two compete, in either mode. A stale valid bit shows up as a request being served twice, or as a dropped request reappearing after the queue drains. A hit test that ignores `open_valid` or compares the wrong row shows up as a wrong `pick_cmd` class in the very cycle the open row changes. The stimulus gives every request a distinct column, so `pick_col` identifies which entry was chosen.

// File: rtl/frq_pkg.sv
package frq_pkg;

    typedef enum logic [1:0] {
        CMD_RD  = 2'd0,
        CMD_WR  = 2'd1,
        CMD_ACT = 2'd2,
        CMD_PRE = 2'd3
    } frq_cmd_e;

endpackage

// File: rtl/frq_store.sv
module frq_store #(
    parameter int DEPTH = 8,
    parameter int ROW_W = 14,
    parameter int COL_W = 11,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          enq_valid,
    input  logic [ROW_W-1:0]              enq_row,
    input  logic [COL_W-1:0]              enq_col,
    input  logic                          enq_wr,
    input  logic                          deq,
    input  logic [IDX_W-1:0]              deq_idx,
    output logic                          enq_ready,
    output logic [DEPTH-1:0]              vld,
    output logic [DEPTH-1:0][ROW_W-1:0]   rows,
    output logic [DEPTH-1:0][COL_W-1:0]   cols,
    output logic [DEPTH-1:0]              wrs,
    output logic [DEPTH-1:0][DEPTH-1:0]   older
);

    typedef struct packed {
        logic [DEPTH-1:0]              vld;
        logic [DEPTH-1:0][ROW_W-1:0]   row;
        logic [DEPTH-1:0][COL_W-1:0]   col;
        logic [DEPTH-1:0]              wr;
        logic [DEPTH-1:0][DEPTH-1:0]   older;
    } store_t;

    store_t           st_d, st_q;
    logic             full;
    logic             enq_acc;
    logic [IDX_W-1:0] free_idx;
    logic             free_found;

    always_comb begin
        st_d       = st_q;
        full       = &st_q.vld;
        enq_acc    = enq_valid && !full;
        free_idx   = '0;
        free_found = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!st_q.vld[i] && !free_found) begin
                free_idx   = IDX_W'(i);
                free_found = 1'b1;
            end
        end
        if (deq) begin
            st_d.vld[deq_idx] = 1'b0;
        end
        if (enq_acc) begin
            st_d.vld[free_idx] = 1'b1;
            st_d.row[free_idx] = enq_row;
            st_d.col[free_idx] = enq_col;
            st_d.wr[free_idx]  = enq_wr;
            for (int j = 0; j < DEPTH; j++) begin
                st_d.older[free_idx][j] = 1'b0;
            end
            for (int j = 0; j < DEPTH; j++) begin
                st_d.older[j][free_idx] = st_q.vld[j] && !(deq && deq_idx == IDX_W'(j));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign enq_ready = !full;
    assign vld       = st_q.vld;
    assign rows      = st_q.row;
    assign cols      = st_q.col;
    assign wrs       = st_q.wr;
    assign older     = st_q.older;

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !deq) |=> (st_q.vld == $past(st_q.vld)));

    // R8
    deq_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        deq |-> st_q.vld[deq_idx]);

    // R8
    deq_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (deq && !enq_acc) |=> ($countones(st_q.vld) + 1 == $past($countones(st_q.vld))));

    generate
        for (genvar a = 0; a < DEPTH; a++) begin : g_pair_a
            for (genvar b = a + 1; b < DEPTH; b++) begin : g_pair_b
                // R9
                age_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (st_q.vld[a] && st_q.vld[b]) |-> (st_q.older[a][b] != st_q.older[b][a]));
            end
        end
    endgenerate

endmodule

// File: rtl/frq_pick.sv
module frq_pick
    import frq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int ROW_W = 14,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [DEPTH-1:0]              vld,
    input  logic [DEPTH-1:0][ROW_W-1:0]   rows,
    input  logic [DEPTH-1:0]              wrs,
    input  logic [DEPTH-1:0][DEPTH-1:0]   older,
    input  logic                          open_valid,
    input  logic [ROW_W-1:0]              open_row,
    input  logic                          fcfs_mode,
    output logic                          pick_valid,
    output logic [IDX_W-1:0]              pick_idx,
    output frq_cmd_e                      pick_cmd
);

    logic [DEPTH-1:0] hit;
    logic [DEPTH-1:0] cand;
    logic [DEPTH-1:0] win;
    logic             use_hit;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            hit[i] = vld[i] && open_valid && (rows[i] == open_row);
        end
        use_hit = !fcfs_mode && (|hit);
        cand    = use_hit ? hit : vld;
        for (int i = 0; i < DEPTH; i++) begin
            win[i] = cand[i];
            for (int j = 0; j < DEPTH; j++) begin
                if (j != i && cand[j] && !older[i][j]) begin
                    win[i] = 1'b0;
                end
            end
        end
        pick_valid = |vld;
        pick_idx   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (win[i]) begin
                pick_idx = IDX_W'(i);
            end
        end
        if (hit[pick_idx]) begin
            pick_cmd = wrs[pick_idx] ? CMD_WR : CMD_RD;
        end else if (open_valid) begin
            pick_cmd = CMD_PRE;
        end else begin
            pick_cmd = CMD_ACT;
        end
    end

    // R5
    single_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pick_valid |-> $onehot(win));

    // R4
    hit_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fcfs_mode && (|hit)) |-> hit[pick_idx]);

    generate
        for (genvar k = 0; k < DEPTH; k++) begin : g_fcfs
            // R3
            fcfs_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (fcfs_mode && pick_valid && vld[k]) |-> !older[k][pick_idx]);
        end
    endgenerate

endmodule

// File: rtl/frfcfs_sched.sv
module frfcfs_sched
    import frq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int ROW_W = 14,
    parameter int COL_W = 11,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enq_valid,
    input  logic [ROW_W-1:0]  enq_row,
    input  logic [COL_W-1:0]  enq_col,
    input  logic              enq_wr,
    output logic              enq_ready,
    input  logic              open_valid,
    input  logic [ROW_W-1:0]  open_row,
    input  logic              fcfs_mode,
    input  logic              sel_en,
    output logic              pick_valid,
    output logic [IDX_W-1:0]  pick_idx,
    output logic [ROW_W-1:0]  pick_row,
    output logic [COL_W-1:0]  pick_col,
    output logic              pick_wr,
    output logic [1:0]        pick_cmd,
    output logic              deq
);

    logic [DEPTH-1:0]              vld;
    logic [DEPTH-1:0][ROW_W-1:0]   rows;
    logic [DEPTH-1:0][COL_W-1:0]   cols;
    logic [DEPTH-1:0]              wrs;
    logic [DEPTH-1:0][DEPTH-1:0]   older;
    frq_cmd_e                      cmd;

    frq_store #(.DEPTH(DEPTH), .ROW_W(ROW_W), .COL_W(COL_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .enq_valid (enq_valid),
        .enq_row   (enq_row),
        .enq_col   (enq_col),
        .enq_wr    (enq_wr),
        .deq       (deq),
        .deq_idx   (pick_idx),
        .enq_ready (enq_ready),
        .vld       (vld),
        .rows      (rows),
        .cols      (cols),
        .wrs       (wrs),
        .older     (older)
    );

    frq_pick #(.DEPTH(DEPTH), .ROW_W(ROW_W)) u_pick (
        .clk        (clk),
        .rst_n      (rst_n),
        .vld        (vld),
        .rows       (rows),
        .wrs        (wrs),
        .older      (older),
        .open_valid (open_valid),
        .open_row   (open_row),
        .fcfs_mode  (fcfs_mode),
        .pick_valid (pick_valid),
        .pick_idx   (pick_idx),
        .pick_cmd   (cmd)
    );

    assign pick_row = rows[pick_idx];
    assign pick_col = cols[pick_idx];
    assign pick_wr  = wrs[pick_idx];
    assign pick_cmd = cmd;
    assign deq      = sel_en && pick_valid;

    // R6
    cmd_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_valid && open_valid && pick_row == open_row) |-> (pick_cmd == {1'b0, pick_wr}));

endmodule

// File: tb/frfcfs_sched_test.sv
`timescale 1ns/1ps
module frfcfs_sched_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enq_valid = 1'b0;
    logic [13:0] enq_row = '0;
    logic [10:0] enq_col = '0;
    logic        enq_wr = 1'b0;
    logic        enq_ready;
    logic        open_valid = 1'b0;
    logic [13:0] open_row = '0;
    logic        fcfs_mode = 1'b0;
    logic        sel_en = 1'b0;
    logic        pick_valid;
    logic [2:0]  pick_idx;
    logic [13:0] pick_row;
    logic [10:0] pick_col;
    logic        pick_wr;
    logic [1:0]  pick_cmd;
    logic        deq;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    frfcfs_sched uut (
        .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_row(enq_row),
        .enq_col(enq_col), .enq_wr(enq_wr), .enq_ready(enq_ready),
        .open_valid(open_valid), .open_row(open_row), .fcfs_mode(fcfs_mode),
        .sel_en(sel_en), .pick_valid(pick_valid), .pick_idx(pick_idx),
        .pick_row(pick_row), .pick_col(pick_col), .pick_wr(pick_wr),
        .pick_cmd(pick_cmd), .deq(deq)
    );

    typedef struct packed {
        logic        enq;
        logic [13:0] row;
        logic [10:0] col;
        logic        wr;
        logic        ov;
        logic [13:0] orow;
        logic        fcfs;
        logic        sel;
        logic        ev;
        logic [10:0] ecol;
        logic [1:0]  ecmd;
        logic [3:0]  tag;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        // load four requests, bank closed: R6 activate class
        '{1'b1, 14'd10, 11'd1, 1'b0, 1'b0, 14'd0,  1'b0, 1'b0, 1'b0, 11'd0, 2'd0, 4'd1},
        '{1'b1, 14'd20, 11'd2, 1'b1, 1'b0, 14'd0,  1'b0, 1'b0, 1'b1, 11'd1, 2'd2, 4'd6},
        '{1'b1, 14'd10, 11'd3, 1'b0, 1'b0, 14'd0,  1'b0, 1'b0, 1'b1, 11'd1, 2'd2, 4'd6},
        '{1'b1, 14'd30, 11'd4, 1'b1, 1'b0, 14'd0,  1'b0, 1'b0, 1'b1, 11'd1, 2'd2, 4'd5},
        // R4 and R7: open row 20 makes the write hit win
        '{1'b0, 14'd0,  11'd0, 1'b0, 1'b1, 14'd20, 1'b0, 1'b0, 1'b1, 11'd2, 2'd1, 4'd4},
        // R5: two hits on row 10, the earlier one wins
        '{1'b0, 14'd0,  11'd0, 1'b0, 1'b1, 14'd10, 1'b0, 1'b0, 1'b1, 11'd1, 2'd0, 4'd5},
        // R3: strict mode ignores the hit on row 20
        '{1'b0, 14'd0,  11'd0, 1'b0, 1'b1, 14'd20, 1'b1, 1'b0, 1'b1, 11'd1, 2'd3, 4'd3},
        // R6: no open row, oldest needs activate
        '{1'b0, 14'd0,  11'd0, 1'b0, 1'b0, 14'd20, 1'b0, 1'b0, 1'b1, 11'd1, 2'd2, 4'd6},
        // R8: take the youngest because it hits
        '{1'b0, 14'd0,  11'd0, 1'b0, 1'b1, 14'd30, 1'b0, 1'b1, 1'b1, 11'd4, 2'd1, 4'd8},
        '{1'b0, 14'd0,  11'd0, 1'b0, 1'b1, 14'd10, 1'b0, 1'b1, 1'b1, 11'd1, 2'd0, 4'd8},
        // R9: enqueue and dequeue together
        '{1'b1, 14'd10, 11'd5, 1'b0, 1'b1, 14'd10, 1'b0, 1'b1, 1'b1, 11'd3, 2'd0, 4'd9},
        '{1'b0, 14'd0,  11'd0, 1'b0, 1'b1, 14'd10, 1'b0, 1'b0, 1'b1, 11'd5, 2'd0, 4'd9},
        // R6: different row open gives precharge
        '{1'b0, 14'd0,  11'd0, 1'b0, 1'b1, 14'd99, 1'b0, 1'b0, 1'b1, 11'd2, 2'd3, 4'd6},
        // R3: strict mode takes the earlier miss over the later hit
        '{1'b0, 14'd0,  11'd0, 1'b0, 1'b1, 14'd10, 1'b1, 1'b1, 1'b1, 11'd2, 2'd3, 4'd3},
        '{1'b1, 14'd40, 11'd6, 1'b1, 1'b1, 14'd10, 1'b0, 1'b1, 1'b1, 11'd5, 2'd0, 4'd9},
        '{1'b0, 14'd0,  11'd0, 1'b0, 1'b0, 14'd10, 1'b0, 1'b1, 1'b1, 11'd6, 2'd2, 4'd8},
        // R8: empty queue gives no dequeue
        '{1'b0, 14'd0,  11'd0, 1'b0, 1'b0, 14'd10, 1'b0, 1'b1, 1'b0, 11'd0, 2'd0, 4'd8}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive(input logic e, input logic [13:0] r, input logic [10:0] c,
                         input logic w, input logic ov, input logic [13:0] orw,
                         input logic f, input logic s);
        enq_valid = e; enq_row = r; enq_col = c; enq_wr = w;
        open_valid = ov; open_row = orw; fcfs_mode = f; sel_en = s;
    endtask

    initial begin
        #200000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1
        chk("R1 pick_valid", 32'(pick_valid), 32'd0);
        chk("R1 enq_ready", 32'(enq_ready), 32'd1);
        chk("R1 deq", 32'(deq), 32'd0);
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            drive(VEC[v].enq, VEC[v].row, VEC[v].col, VEC[v].wr,
                  VEC[v].ov, VEC[v].orow, VEC[v].fcfs, VEC[v].sel);
            #1;
            chk($sformatf("R%0d valid v%0d", VEC[v].tag, v), 32'(pick_valid), 32'(VEC[v].ev));
            if (VEC[v].ev) begin
                chk($sformatf("R%0d col v%0d", VEC[v].tag, v), 32'(pick_col), 32'(VEC[v].ecol));
                chk($sformatf("R%0d cmd v%0d", VEC[v].tag, v), 32'(pick_cmd), 32'(VEC[v].ecmd));
            end
            chk($sformatf("R%0d deq v%0d", VEC[v].tag, v), 32'(deq), 32'(VEC[v].sel & VEC[v].ev));
            chk($sformatf("R%0d ready v%0d", VEC[v].tag, v), 32'(enq_ready), 32'd1);
            @(negedge clk);
        end

        // R2: fill to capacity in strict mode
        for (int k = 0; k < 8; k++) begin
            drive(1'b1, 14'd50, 11'(100 + k), 1'b0, 1'b0, 14'd0, 1'b1, 1'b0);
            @(negedge clk);
        end
        drive(1'b0, 14'd0, 11'd0, 1'b0, 1'b0, 14'd0, 1'b1, 1'b0);
        #1;
        chk("R2 full ready", 32'(enq_ready), 32'd0);
        @(negedge clk);
        // R2: offer while full together with a dequeue
        drive(1'b1, 14'd50, 11'd200, 1'b0, 1'b0, 14'd0, 1'b1, 1'b1);
        #1;
        chk("R2 full ready", 32'(enq_ready), 32'd0);
        chk("R8 full deq", 32'(deq), 32'd1);
        chk("R3 full oldest", 32'(pick_col), 32'd100);
        @(negedge clk);
        for (int k = 1; k < 8; k++) begin
            drive(1'b0, 14'd0, 11'd0, 1'b0, 1'b0, 14'd0, 1'b1, 1'b1);
            #1;
            chk("R3 drain order", 32'(pick_col), 32'(100 + k));
            @(negedge clk);
        end
        drive(1'b0, 14'd0, 11'd0, 1'b0, 1'b0, 14'd0, 1'b1, 1'b0);
        #1;
        chk("R2 dropped absent", 32'(pick_valid), 32'd0);
        @(negedge clk);

        // R9: reuse of freed slots keeps arrival order
        drive(1'b1, 14'd7, 11'd300, 1'b0, 1'b0, 14'd0, 1'b0, 1'b0);
        @(negedge clk);
        drive(1'b1, 14'd8, 11'd301, 1'b0, 1'b0, 14'd0, 1'b0, 1'b0);
        @(negedge clk);
        drive(1'b1, 14'd7, 11'd302, 1'b1, 1'b1, 14'd8, 1'b0, 1'b1);
        #1;
        chk("R9 reuse pick", 32'(pick_col), 32'd301);
        @(negedge clk);
        drive(1'b0, 14'd0, 11'd0, 1'b0, 1'b1, 14'd7, 1'b0, 1'b1);
        #1;
        chk("R9 reuse older hit", 32'(pick_col), 32'd300);
        @(negedge clk);
        drive(1'b0, 14'd0, 11'd0, 1'b0, 1'b1, 14'd7, 1'b0, 1'b0);
        #1;
        chk("R9 reuse newest", 32'(pick_col), 32'd302);
        chk("R6 write hit", 32'(pick_cmd), 32'd1);
        @(negedge clk);

        // R1: reset in mid run empties the queue
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 mid reset valid", 32'(pick_valid), 32'd0);
        chk("R1 mid reset ready", 32'(enq_ready), 32'd1);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule